// File: doc/BRIEF.md
# Shift-Add Logistic Curve Unit

This block gives a close-enough value of the logistic function 1/(1+e^-x) for a stream of signed fixed-point samples. Each sample is a 16-bit two's-complement number with 8 fractional bits. The result comes back in the same format and always lies between zero and one. The curve is made of three straight pieces. Every piece has a power-of-two slope, so a right shift and an adder evaluate it and no multiplier is needed. Beyond the last piece the output is held at a plateau.

The block only works on the magnitude of the input. It then mirrors the result for negative samples, using the fact that the curve's value at -x equals one minus its value at x. A valid flag moves through a five-stage pipeline together with the data. A new sample can enter on every clock, and each sample leaves exactly five clocks after it entered. It is intended for use as the activation step after a neuron's accumulator.

Top module: `sig_approx`

## Requirements
- R1: When outValid is high, outData lies in 0..255, meaning 0 up to 255/256 in the 8-fractional-bit format. Bits 15:8 of outData are then zero.
- R2: A sample taken with inValid high at a rising edge appears with outValid high at the fifth rising edge after that one. Samples presented on consecutive clocks come out on consecutive clocks, and in order.
- R3: For magnitude m = |inData| (read as an integer count of 1/256 units) below 256, the positive-side value is 128 + floor(m/4).
- R4: For m from 256 to 607 (1.0 up to just under 2.375), the positive-side value is 160 + floor(m/8).
- R5: For m from 608 to 1279 (2.375 up to just under 5.0), the positive-side value is 216 + floor(m/32), capped at 255.
- R6: For m of 1280 or more, the positive-side value is 255. This includes inData = 16'h8000, whose magnitude is 32768.
- R7: When inData is negative (bit 15 set), outData is 256 minus the positive-side value of m. When inData is non-negative, outData equals that value.
- R8: While outValid is low, outData keeps the last result that was delivered.
- R9: While rstN is low, outValid and outData are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample qualifier |
| inData | input | 16 | Signed input, 8 fractional bits |
| outValid | output | 1 | Result qualifier, five clocks after inValid |
| outData | output | 16 | Result in 0..255/256, 8 fractional bits |

## Verification
Some properties are checked by assertions on every clock. One is the valid alignment, compared against the input five cycles earlier once enough cycles have passed since reset. The others are the bound on every delivered result, the hold of outData while no result is delivered, and the staging properties inside the datapath: the plateau for large magnitudes and the central band for magnitudes below one. The exact arithmetic of each segment, the mirror for negative inputs, the breakpoint edges and the extreme codes can only be shown by the bench. It sweeps and probes inputs against its own model of the curve.

// File: rtl/sig_approx_pkg.sv
package sig_approx_pkg;

  // Strobes from the control to the datapath: one load per stage.
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
    logic ld5;
  } stageLd_t;

  localparam int NUM_BP = 3;
  localparam int NUM_STAGES = 5;

  // Segment boundaries on |x|: 1.0, 2.375 and 5.0.
  function automatic int bpOf(input int idx, input int frac);
    case (idx)
      0:       return 1 << frac;
      1:       return (19 << frac) >> 3;
      default: return 5 << frac;
    endcase
  endfunction

  // Right-shift amount of each segment (slope is 2^-shift).
  function automatic int shOf(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      default: return 5;
    endcase
  endfunction

  // Offsets 0.5, 0.625 and 0.84375.
  function automatic int offOf(input int idx, input int frac);
    case (idx)
      0:       return (1 << frac) >> 1;
      1:       return (5 << frac) >> 3;
      default: return (27 << frac) >> 5;
    endcase
  endfunction

endpackage

// File: rtl/sig_approx_ctrl.sv
module sig_approx_ctrl
  import sig_approx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output stageLd_t ld,
  output logic     outValid
);

  localparam int CNT_W = $clog2(NUM_STAGES + 1);

  logic [NUM_STAGES-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[NUM_STAGES-2:0], inValid};
  end

  always_comb begin
    ld.ld1 = inValid;
    ld.ld2 = vPipe[0];
    ld.ld3 = vPipe[1];
    ld.ld4 = vPipe[2];
    ld.ld5 = vPipe[3];
  end

  assign outValid = vPipe[NUM_STAGES-1];

  // Cycles since reset, saturating, so the latency check never looks before reset.
  logic [CNT_W-1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != CNT_W'(NUM_STAGES)) sinceRst <= sinceRst + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CNT_W'(NUM_STAGES)) |-> (outValid == $past(inValid, 5)));

endmodule

// File: rtl/sig_approx_dp.sv
module sig_approx_dp
  import sig_approx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageLd_t          ld,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  localparam int SEG_W = $clog2(NUM_BP + 1);
  localparam logic [FRAC_W-1:0] MAXV = '1;
  localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1 << FRAC_W);
  localparam logic [DATA_W-1:0] BP_SAT = DATA_W'(bpOf(NUM_BP - 1, FRAC_W));
  localparam logic [DATA_W-1:0] BP_ONE = DATA_W'(bpOf(0, FRAC_W));

  // Stage 1: capture
  logic [DATA_W-1:0] xS1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       xS1 <= '0;
    else if (ld.ld1) xS1 <= inData;
  end

  // Stage 2: magnitude and sign
  logic [DATA_W-1:0] magS2;
  logic              negS2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magS2 <= '0;
      negS2 <= 1'b0;
    end else if (ld.ld2) begin
      magS2 <= xS1[DATA_W-1] ? (~xS1 + DATA_W'(1)) : xS1;
      negS2 <= xS1[DATA_W-1];
    end
  end

  // Stage 3: segment index = number of boundaries at or below |x|
  logic [NUM_BP-1:0] aboveBp;
  for (genvar gi = 0; gi < NUM_BP; gi++) begin : g_bp
    assign aboveBp[gi] = (magS2 >= DATA_W'(bpOf(gi, FRAC_W)));
  end

  logic [SEG_W-1:0] segNext;
  always_comb begin
    segNext = '0;
    for (int i = 0; i < NUM_BP; i++) segNext = segNext + SEG_W'(aboveBp[i]);
  end

  logic [SEG_W-1:0]  segS3;
  logic [DATA_W-1:0] magS3;
  logic              negS3;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segS3 <= '0;
      magS3 <= '0;
      negS3 <= 1'b0;
    end else if (ld.ld3) begin
      segS3 <= segNext;
      magS3 <= magS2;
      negS3 <= negS2;
    end
  end

  // Stage 4: shift, add offset, saturate
  logic [FRAC_W-1:0] posNext;
  always_comb begin
    int sumI;
    sumI = 0;
    posNext = MAXV;
    for (int i = 0; i < NUM_BP; i++) begin
      if (int'(segS3) == i) begin
        sumI = offOf(i, FRAC_W) + int'(magS3 >> shOf(i));
        posNext = (sumI > int'(MAXV)) ? MAXV : FRAC_W'(sumI);
      end
    end
  end

  logic [FRAC_W-1:0] posS4;
  logic              negS4;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posS4 <= '0;
      negS4 <= 1'b0;
    end else if (ld.ld4) begin
      posS4 <= posNext;
      negS4 <= negS3;
    end
  end

  // Stage 5: mirror for negative inputs
  logic [FRAC_W:0] mirNext;
  assign mirNext = negS4 ? (ONE - {1'b0, posS4}) : {1'b0, posS4};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       outData <= '0;
    else if (ld.ld5) outData <= {{(DATA_W-FRAC_W-1){1'b0}}, mirNext};
  end

  // R6
  sat_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ld.ld4 && magS3 >= BP_SAT) |=> (posS4 == MAXV));

  // R3
  mid_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ld.ld4 && magS3 < BP_ONE) |=>
      (posS4 >= FRAC_W'(1 << (FRAC_W - 1)) && posS4 < FRAC_W'(3 << (FRAC_W - 2))));

endmodule

// File: rtl/sig_approx.sv
module sig_approx
  import sig_approx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  stageLd_t ld;

  sig_approx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ld       (ld),
    .outValid (outValid)
  );

  sig_approx_dp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ld      (ld),
    .inData  (inData),
    .outData (outData)
  );

  // R1
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData < DATA_W'(1 << FRAC_W)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

endmodule

// File: tb/sig_approx_test.sv
module sig_approx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [15:0] outData;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sig_approx uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  // Behavioural curve, straight from the requirements.
  function automatic int curve(input int x);
    int m, p;
    m = (x < 0) ? -x : x;
    if (m < 256)       p = 128 + m / 4;              // R3
    else if (m < 608)  p = 160 + m / 8;              // R4
    else if (m < 1280) p = (216 + m / 32 > 255) ? 255 : 216 + m / 32; // R5
    else               p = 255;                      // R6
    return (x < 0) ? 256 - p : p;                    // R7
  endfunction

  function automatic string tagOf(input int x);
    int m;
    m = (x < 0) ? -x : x;
    if (x < 0)     return "R7";
    if (m < 256)   return "R3";
    if (m < 608)   return "R4";
    if (m < 1280)  return "R5";
    return "R6";
  endfunction

  // Model pipeline: index 0 newest, index 4 is what the output shows.
  int    pV[5];
  int    pY[5];
  string pT[5];
  int    heldY = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) begin pV[i] = 0; pY[i] = 0; pT[i] = "R2"; end
      heldY = 0;
    end else begin
      for (int i = 4; i > 0; i--) begin pV[i] = pV[i-1]; pY[i] = pY[i-1]; pT[i] = pT[i-1]; end
      pV[0] = inValid ? 1 : 0;
      pY[0] = curve(int'($signed(inData)));
      pT[0] = tagOf(int'($signed(inData)));
      if (pV[4] != 0) heldY = pY[4];
    end
  end

  always @(negedge clk) begin
    if (running && rstN) begin
      compared++;
      if (int'(outValid) != pV[4]) begin
        mismatched++;
        $display("FAIL R2 outValid actual=%0d expected=%0d", outValid, pV[4]);
      end else if (pV[4] != 0 && int'(outData) != pY[4]) begin
        mismatched++;
        $display("FAIL %s/R1 outData actual=%0d expected=%0d", pT[4], outData, pY[4]);
      end else if (pV[4] == 0 && int'(outData) != heldY) begin
        mismatched++;
        $display("FAIL R8 held outData actual=%0d expected=%0d", outData, heldY);
      end
    end
  end

  task automatic send(input int x);
    @(negedge clk);
    inValid = 1'b1;
    inData = 16'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData = 16'h5A5A;
    end
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    compared++;
    if (outValid !== 1'b0 || outData !== 16'h0000) begin
      mismatched++;
      $display("FAIL R9 reset actual=%0d/%0d expected=0/0", outValid, outData);
    end
    rstN = 1'b1;
    running = 1'b1;
    idle(2);

    // Breakpoint edges and extremes, back to back (R3..R7)
    send(0); send(255); send(256); send(607); send(608);
    send(1279); send(1280); send(-1); send(-256); send(-607);
    send(-608); send(-1280); send(-32768); send(32767);
    send(21760); send(-12800); send(1248); send(1247);
    idle(8);  // R8: output holds during the gap

    // Sweep across all segments, one sample per clock (R2)
    for (int x = -1400; x <= 1400; x += 3) send(x);
    idle(3);

    // Alternating valid pattern
    for (int k = 0; k < 60; k++) begin
      send(k * 37 - 1100);
      idle(k % 3);
    end

    // Wide-range pseudo-random values
    for (int k = 0; k < 200; k++) send((k * 40503 + 12345) % 65536 - 32768);
    idle(10);

    done = 1'b1;
    finishRun();
  end

endmodule